// File: doc/BRIEF.md
# Closed-Loop PWM Period and Duty Regulator

This block keeps a regulated output voltage inside a window by steering both the period and the duty of a PWM waveform. Each strobed reading from a free-running converter is compared with a target value and with a lower and an upper limit. A reading beyond the upper limit lengthens the period. A reading beneath the lower limit shortens it. A reading inside the window nudges the duty by one count toward the target.

The duty is kept between two bounds taken from the current period by a right shift: the shifted value at the bottom, and the period less that value at the top. Whenever the period actually changes, the duty restarts from half of the new period. When a reading stays outside the window, every further sample moves the period again, until the loop reaches a period and duty pair that holds the reading inside. Adjustments build up in a pending set of registers. That set is copied into the running counter only at a period boundary, so the counter never runs on a mixed pair.

Top module: `pwm_reg_loop`

## Requirements
- R1: A synchronous reset sets the period to 256 (PER_MAX), the duty to 128 and the in-regulation flag to 0.
- R2: A strobed reading inside the window changes the duty by +1 when it is above the target, by -1 when it is below the target, and by 0 when it equals the target.
- R3: The duty never goes below period>>4 or above period-(period>>4). A step that would cross either bound leaves the duty on the bound, with no wraparound.
- R4: A strobed reading above the upper limit adds 16 to the period, saturating at 256. A reading below the lower limit subtracts 16, saturating at 32 (PER_MIN).
- R5: Every change of period reloads the duty with half the new period. A period step that is blocked by saturation changes neither the period nor the duty.
- R6: Each valid strobe makes exactly one adjustment. Strobes on consecutive cycles make one adjustment each. A reading presented without the strobe has no effect.
- R7: The in-regulation flag reports whether the most recent strobed reading lay between the lower and upper limits, both limits included.
- R8: The period, duty and flag outputs change only at a PWM period boundary. A strobe therefore shows at the outputs only after the period that is running when it arrives.
- R9: During each period of P counts, pwm_out is high for the first D counts, where P and D are the period and duty currently shown at the outputs (INVERT=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Strobe qualifying smp_data |
| smp_data | input | 8 | Converter reading |
| tgt | input | 8 | Target reading |
| lim_lo | input | 8 | Lower window limit (inclusive) |
| lim_hi | input | 8 | Upper window limit (inclusive) |
| pwm_out | output | 1 | PWM waveform |
| period_out | output | 9 | Period in use, in counts |
| duty_out | output | 9 | Duty in use, in counts |
| in_reg | output | 1 | In-regulation flag |

## Verification
A wrong pending period or duty stays invisible until the next period boundary. After that boundary it appears on period_out and duty_out, and over the following full period it appears in the number of high cycles on pwm_out. Each check therefore waits one whole running period after a strobe before it reads the outputs. Faults in saturation or re-centring show up only at the edges of the range, so directed runs drive the period down to 32 and walk the duty onto both of its bounds. A strobe issued just after reset shows whether the update was held back until the boundary.

// File: rtl/pwm_reg_pkg.sv
package pwm_reg_pkg;

  // Decision taken for one strobed reading
  typedef enum logic [2:0] {
    ADJ_HOLD = 3'd0,
    ADJ_DUP  = 3'd1,
    ADJ_DDN  = 3'd2,
    ADJ_PUP  = 3'd3,
    ADJ_PDN  = 3'd4
  } adj_kind_e;

  // Lowest duty the loop may use for a given period
  function automatic int duty_floor(input int per, input int sh);
    return per >> sh;
  endfunction

  // Highest duty the loop may use for a given period
  function automatic int duty_ceil(input int per, input int sh);
    return per - (per >> sh);
  endfunction

  // Duty loaded after a period change
  function automatic int duty_centre(input int per);
    return per >> 1;
  endfunction

endpackage

// File: rtl/pwm_window_cmp.sv
module pwm_window_cmp
  import pwm_reg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] tgt,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output adj_kind_e     kind,
  output logic          in_win
);

  logic above_hi;
  logic below_lo;

  assign above_hi = smp > hi;
  assign below_lo = smp < lo;
  assign in_win   = !above_hi && !below_lo;

  always_comb begin
    if (above_hi)       kind = ADJ_PUP;
    else if (below_lo)  kind = ADJ_PDN;
    else if (smp > tgt) kind = ADJ_DUP;
    else if (smp < tgt) kind = ADJ_DDN;
    else                kind = ADJ_HOLD;
  end

endmodule

// File: rtl/pwm_adjust_core.sv
module pwm_adjust_core
  import pwm_reg_pkg::*;
#(
  parameter int PW       = 9,
  parameter int PER_MAX  = 256,
  parameter int PER_MIN  = 32,
  parameter int PER_STEP = 16,
  parameter int SHIFT    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  adj_kind_e     kind,
  input  logic          in_win,
  output logic [PW-1:0] per_q,
  output logic [PW-1:0] duty_q,
  output logic          flag_q,
  output logic [PW-1:0] lo_lim,
  output logic [PW-1:0] hi_lim,
  output logic          per_chg
);

  localparam int EW = PW + 1;
  localparam logic [EW-1:0] MAX_E  = EW'(PER_MAX);
  localparam logic [EW-1:0] MIN_E  = EW'(PER_MIN);
  localparam logic [EW-1:0] STEP_E = EW'(PER_STEP);

  logic [EW-1:0] up_sum;
  logic [PW-1:0] per_up;
  logic [PW-1:0] per_dn;
  logic [PW-1:0] per_nxt;
  logic [PW-1:0] duty_nxt;

  assign lo_lim = PW'(duty_floor(int'(per_q), SHIFT));
  assign hi_lim = PW'(duty_ceil(int'(per_q), SHIFT));

  assign up_sum = {1'b0, per_q} + STEP_E;
  assign per_up = (up_sum > MAX_E) ? PW'(PER_MAX) : up_sum[PW-1:0];
  assign per_dn = ({1'b0, per_q} < (MIN_E + STEP_E)) ? PW'(PER_MIN)
                                                     : per_q - PW'(PER_STEP);

  always_comb begin
    case (kind)
      ADJ_PUP: per_nxt = per_up;
      ADJ_PDN: per_nxt = per_dn;
      default: per_nxt = per_q;
    endcase
  end

  assign per_chg = strobe && (per_nxt != per_q);

  always_comb begin
    duty_nxt = duty_q;
    if (per_chg) begin
      duty_nxt = PW'(duty_centre(int'(per_nxt)));
    end else if (kind == ADJ_DUP) begin
      duty_nxt = (duty_q >= hi_lim) ? hi_lim : duty_q + 1'b1;
    end else if (kind == ADJ_DDN) begin
      duty_nxt = (duty_q <= lo_lim) ? lo_lim : duty_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= PW'(PER_MAX);
      duty_q <= PW'(PER_MAX / 2);
      flag_q <= 1'b0;
    end else if (strobe) begin
      per_q  <= per_nxt;
      duty_q <= duty_nxt;
      flag_q <= in_win;
    end
  end

endmodule

// File: rtl/pwm_engine.sv
module pwm_engine #(
  parameter int PW      = 9,
  parameter int PER_MAX = 256,
  parameter bit INVERT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] per_pend,
  input  logic [PW-1:0] duty_pend,
  input  logic          flag_pend,
  output logic [PW-1:0] per_act,
  output logic [PW-1:0] duty_act,
  output logic          flag_act,
  output logic          wrap,
  output logic          pwm
);

  logic [PW-1:0] cnt;
  logic          on_time;

  assign wrap    = (cnt == per_act - 1'b1);
  assign on_time = cnt < duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      per_act  <= PW'(PER_MAX);
      duty_act <= PW'(PER_MAX / 2);
      flag_act <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      per_act  <= per_pend;
      duty_act <= duty_pend;
      flag_act <= flag_pend;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  generate
    if (INVERT) begin : g_low
      assign pwm = !on_time;
    end else begin : g_high
      assign pwm = on_time;
    end
  endgenerate

endmodule

// File: rtl/pwm_reg_loop.sv
module pwm_reg_loop
  import pwm_reg_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PW       = 9,
  parameter int PER_MAX  = 256,
  parameter int PER_STEP = 16,
  parameter int SHIFT    = 4,
  parameter int MIN_FLOOR = 2,
  parameter bit INVERT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] tgt,
  input  logic [DW-1:0] lim_lo,
  input  logic [DW-1:0] lim_hi,
  output logic          pwm_out,
  output logic [PW-1:0] period_out,
  output logic [PW-1:0] duty_out,
  output logic          in_reg
);

  // Shortest period whose shifted duty floor still equals MIN_FLOOR
  localparam int PER_MIN = MIN_FLOOR << SHIFT;

  adj_kind_e     kind;
  logic          in_win;
  logic [PW-1:0] per_pend;
  logic [PW-1:0] duty_pend;
  logic          flag_pend;
  logic [PW-1:0] lo_lim;
  logic [PW-1:0] hi_lim;
  logic          per_chg;
  logic          wrap;

  pwm_window_cmp #(.DW(DW)) u_cmp (
    .smp    (smp_data),
    .tgt    (tgt),
    .lo     (lim_lo),
    .hi     (lim_hi),
    .kind   (kind),
    .in_win (in_win)
  );

  pwm_adjust_core #(
    .PW(PW), .PER_MAX(PER_MAX), .PER_MIN(PER_MIN),
    .PER_STEP(PER_STEP), .SHIFT(SHIFT)
  ) u_adj (
    .clk     (clk),
    .rst     (rst),
    .strobe  (smp_valid),
    .kind    (kind),
    .in_win  (in_win),
    .per_q   (per_pend),
    .duty_q  (duty_pend),
    .flag_q  (flag_pend),
    .lo_lim  (lo_lim),
    .hi_lim  (hi_lim),
    .per_chg (per_chg)
  );

  pwm_engine #(.PW(PW), .PER_MAX(PER_MAX), .INVERT(INVERT)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .per_pend  (per_pend),
    .duty_pend (duty_pend),
    .flag_pend (flag_pend),
    .per_act   (period_out),
    .duty_act  (duty_out),
    .flag_act  (in_reg),
    .wrap      (wrap),
    .pwm       (pwm_out)
  );

endmodule

// File: rtl/pwm_reg_loop_chk.sv
module pwm_reg_loop_chk
  import pwm_reg_pkg::*;
#(
  parameter int PW      = 9,
  parameter int PER_MAX = 256,
  parameter int PER_MIN = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          smp_valid,
  input logic [PW-1:0] period_out,
  input logic [PW-1:0] duty_out,
  input logic          in_reg,
  input logic [PW-1:0] per_pend,
  input logic [PW-1:0] duty_pend,
  input logic [PW-1:0] lo_lim,
  input logic [PW-1:0] hi_lim,
  input logic          per_chg,
  input logic          wrap,
  input adj_kind_e     kind
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (period_out == PW'(PER_MAX)) && (duty_out == PW'(PER_MAX / 2)) && !in_reg);

  // R2
  duty_step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && kind == ADJ_DUP && !per_chg && duty_pend < hi_lim)
      |=> duty_pend == $past(duty_pend) + 1'b1);

  // R3
  duty_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_pend >= lo_lim) && (duty_pend <= hi_lim));

  // R4
  period_range_chk: assert property (@(posedge clk) disable iff (rst)
    (per_pend >= PW'(PER_MIN)) && (per_pend <= PW'(PER_MAX)));

  // R5
  recentre_chk: assert property (@(posedge clk) disable iff (rst)
    per_chg |=> duty_pend == (per_pend >> 1));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(per_pend) && $stable(duty_pend));

  // R8
  boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(period_out) && $stable(duty_out) && $stable(in_reg));

endmodule

bind pwm_reg_loop pwm_reg_loop_chk #(
  .PW(PW), .PER_MAX(PER_MAX), .PER_MIN(PER_MIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_valid  (smp_valid),
  .period_out (period_out),
  .duty_out   (duty_out),
  .in_reg     (in_reg),
  .per_pend   (per_pend),
  .duty_pend  (duty_pend),
  .lo_lim     (lo_lim),
  .hi_lim     (hi_lim),
  .per_chg    (per_chg),
  .wrap       (wrap),
  .kind       (kind)
);

// File: tb/sim_pwm_reg_loop.sv
module sim_pwm_reg_loop;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic [7:0] tgt = 8'd100;
  logic [7:0] lim_lo = 8'd80;
  logic [7:0] lim_hi = 8'd120;
  logic       pwm_out;
  logic [8:0] period_out;
  logic [8:0] duty_out;
  logic       in_reg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  pwm_reg_loop u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .tgt(tgt), .lim_lo(lim_lo), .lim_hi(lim_hi), .pwm_out(pwm_out),
    .period_out(period_out), .duty_out(duty_out), .in_reg(in_reg)
  );

  // {reading, expected period, expected duty, expected flag}
  localparam logic [26:0] VEC [11] = '{
    {8'd100, 9'd256, 9'd128, 1'b1},  // R2 equal -> hold
    {8'd110, 9'd256, 9'd129, 1'b1},  // R2 up
    {8'd110, 9'd256, 9'd130, 1'b1},  // R2 up
    {8'd90,  9'd256, 9'd129, 1'b1},  // R2 down
    {8'd130, 9'd256, 9'd129, 1'b0},  // R4/R5 max saturation, no recentre
    {8'd70,  9'd240, 9'd120, 1'b0},  // R4/R5 shrink, recentre
    {8'd70,  9'd224, 9'd112, 1'b0},  // R4 shrink again
    {8'd105, 9'd224, 9'd113, 1'b1},  // R2 up, R7
    {8'd125, 9'd240, 9'd120, 1'b0},  // R4 grow, R5
    {8'd80,  9'd240, 9'd119, 1'b1},  // R7 lower limit inclusive
    {8'd120, 9'd240, 9'd120, 1'b1}   // R7 upper limit inclusive
  };

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic check_state(input string req, input int ep, input int ed, input int ef);
    check({req, " period"}, int'(period_out), ep);
    check({req, " duty"}, int'(duty_out), ed);
    check({req, " flag"}, int'(in_reg), ef);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Let any pending update reach the outputs: one full running period and margin
  task automatic settle();
    int n;
    n = int'(period_out) + 3;
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] r);
    @(negedge clk); smp_valid = 1'b1; smp_data = r;
    @(negedge clk); smp_valid = 1'b0;
    settle();
  endtask

  task automatic check_pwm(input string req);
    int hi_n = 0;
    int p;
    p = int'(period_out);
    repeat (p) begin
      @(negedge clk);
      if (pwm_out) hi_n++;
    end
    check(req, hi_n, int'(duty_out));
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check_state("R1 reset", 256, 128, 0);
    check_pwm("R9 high count at reset");

    // R8: strobe right after reset, held back until the boundary
    do_reset();
    smp_valid = 1'b1; smp_data = 8'd110;
    @(negedge clk); smp_valid = 1'b0;
    repeat (100) @(negedge clk);
    check_state("R8 held before boundary", 256, 128, 0);
    repeat (200) @(negedge clk);
    check_state("R8 applied after boundary", 256, 129, 1);
    check_pwm("R9 high count 129");

    do_reset();
    foreach (VEC[i]) begin
      strobe(VEC[i][26:19]);
      check_state($sformatf("vector %0d", i), int'(VEC[i][18:10]),
                  int'(VEC[i][9:1]), int'(VEC[i][0]));
    end

    // R6: reading without strobe is ignored
    @(negedge clk); smp_data = 8'd130;
    repeat (300) @(negedge clk);
    check_state("R6 no strobe", 240, 120, 1);

    // R6: strobes on consecutive cycles, one step each
    @(negedge clk); smp_valid = 1'b1; smp_data = 8'd90;
    @(negedge clk);
    @(negedge clk); smp_valid = 1'b0;
    settle();
    check_state("R6 two strobes", 240, 118, 1);

    // R4: drive period to its minimum
    for (int k = 0; k < 15; k++) strobe(8'd70);
    check_state("R4 min saturation R5", 32, 16, 0);
    check_pwm("R9 high count at min period");

    // R3: lower duty bound 32>>4 = 2
    for (int k = 0; k < 16; k++) strobe(8'd90);
    check_state("R3 lower bound", 32, 2, 1);

    // R3: upper duty bound 32-2 = 30
    for (int k = 0; k < 30; k++) strobe(8'd110);
    check_state("R3 upper bound", 32, 30, 1);
    check_pwm("R9 high count at upper bound");

    strobe(8'd130);
    check_state("R4 grow from min R5", 48, 24, 0);

    do_reset();
    @(negedge clk);
    check_state("R1 mid-run reset", 256, 128, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule